// File: doc/BRIEF.md
# Presettable Cascadable Decade Counter

This block is a four-bit synchronous decade counter. It counts 0 through 9 and wraps, can be preset in parallel from a four-bit data input, and has two count enables. A lookahead carry output lets several instances share one clock and form a multi-digit decimal counter. In a chain, the carry of each digit drives the carry-gating enable of the next digit. The other enable goes to every digit at once and pauses the whole chain.

A build-time parameter selects the clear behaviour. With `SYNC_CLR = 0` an active-low clear empties the counter at once, with no clock needed. With `SYNC_CLR = 1` the clear takes effect on the next rising clock edge. All control pins are plain level inputs, because the block has no data stream and therefore no valid/ready handshake. A preset may hold any of the sixteen four-bit codes. From a code outside 0 to 9, the counter returns to the decimal cycle within two counting clocks.

Top module: `decade_counter`

## Requirements
- R1: A low `clr_n` sets `count` to 0. With SYNC_CLR=0 this takes effect at once and does not wait for the clock. With SYNC_CLR=1 it takes effect at the next rising edge.
- R2: A low clear overrides the preset and the count enables.
- R3: If `clr_n` is high and `load_n` is low, a rising edge copies `din` into `count`, where bit 0 is the least significant bit. Counting is held off while `load_n` stays low.
- R4: If `clr_n`, `load_n`, `en_par` and `en_car` are all high, a rising edge moves `count` from 0 through 9 in order and then from 9 back to 0.
- R5: If `load_n` is high and either `en_par` or `en_car` is low, `count` keeps its value across the edge.
- R6: `tc` equals `en_car` AND (`count` == 4'b1001). It changes with no clock edge, `en_par` has no effect on it, and it stays low for counts 11, 13 and 15.
- R7: When counting is enabled, the codes outside 0 to 9 advance as 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. Every one of them therefore reaches 0 to 9 within two counts.
- R8: Three instances on one clock, each with its `tc` driving the next instance's `en_car` and sharing one `en_par`, count from 000 to 999 and then wrap to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on SYNC_CLR |
| load_n | input | 1 | Active-low parallel preset |
| din | input | 4 | Preset value, bit 0 least significant |
| en_par | input | 1 | Count enable that does not gate the carry |
| en_car | input | 1 | Count enable that also gates the carry |
| count | output | 4 | Registered counter state |
| tc | output | 1 | Lookahead carry, combinational |

## Verification
The hardest case to reach from the ports is the chain rollover, where the carry must pass through two digits in the same edge to take 099 to 100 and 999 to 000. The bench reaches it by running the three-digit chain for more than a full thousand counts. During the run it drops the shared enable at arbitrary moments, including at 9-boundaries, and checks the chain against an integer model on every clock. To reach the codes outside 0 to 9, the bench presets them one at a time and counts through them.

// File: rtl/decade_counter.sv
module decade_counter #(
  parameter bit SYNC_CLR = 1'b0,
  parameter int W        = 4,
  parameter int LAST     = 9
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_par,
  input  logic         en_car,
  output logic [W-1:0] count,
  output logic         tc
);
  localparam logic [W-1:0] TOP = W'(LAST);

  logic         step;
  logic [W-1:0] nxt;

  assign step = load_n & en_par & en_car;

  // next code: decimal successor, fixed escape path for codes above TOP
  always_comb begin
    unique case (count)
      4'd10:   nxt = 4'd11;
      4'd11:   nxt = 4'd6;
      4'd12:   nxt = 4'd13;
      4'd13:   nxt = 4'd4;
      4'd14:   nxt = 4'd15;
      4'd15:   nxt = 4'd2;
      TOP:     nxt = '0;
      default: nxt = count + 1'b1;
    endcase
  end

  generate
    if (SYNC_CLR) begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n)       count <= '0;
        else if (!load_n) count <= din;
        else if (step)    count <= nxt;
      end
    end else begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)       count <= '0;
        else if (!load_n) count <= din;
        else if (step)    count <= nxt;
      end
    end
  endgenerate

  assign tc = en_car & (count == TOP);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_car && count == TOP) |=> count == '0);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_car)) |=> $stable(count));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(din));
  // R7
  escape_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (step && count > TOP && count[0]) |=> count <= TOP);
  // R6
  carry_chk: assert property (@(posedge clk)
    tc |-> (en_car && count[0] && count[3] && !count[1] && !count[2]));
endmodule

// File: tb/sim_decade_counter.sv
module sim_decade_counter;
  logic clk = 0;
  always #5 clk = ~clk;

  int errs = 0, checks = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // single unit, async clear
  logic clr_n = 0, load_n = 1, en_par = 0, en_car = 0;
  logic [3:0] din = 0, count;
  logic tc;
  decade_counter #(.SYNC_CLR(1'b0)) u0 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .din(din), .en_par(en_par), .en_car(en_car), .count(count), .tc(tc));

  // sync-clear unit
  logic s_clr_n = 1, s_load_n = 1;
  logic [3:0] s_din = 0, s_cnt;
  logic s_tc;
  decade_counter #(.SYNC_CLR(1'b1)) u_s (.clk(clk), .clr_n(s_clr_n), .load_n(s_load_n),
    .din(s_din), .en_par(1'b1), .en_car(1'b1), .count(s_cnt), .tc(s_tc));

  // three-digit chain
  logic c_clr_n = 0, c_ep = 0;
  logic [3:0] d0, d1, d2;
  logic t0, t1, t2;
  decade_counter u_c0 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_ep), .en_car(1'b1), .count(d0), .tc(t0));
  decade_counter u_c1 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_ep), .en_car(t0), .count(d1), .tc(t1));
  decade_counter u_c2 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_ep), .en_car(t1), .count(d2), .tc(t2));

  function automatic int esc(int v);
    case (v)
      10: return 11; 11: return 6; 12: return 13;
      13: return 4;  14: return 15; 15: return 2;
      9: return 0;
      default: return v + 1;
    endcase
  endfunction

  task automatic tick(); @(posedge clk); #2; endtask

  initial begin
    int model;
    #2;
    chk("R1 reset state", count, 0);
    // preset and expect count starts one edge later
    clr_n = 1; din = 4'd7; load_n = 0; tick();
    chk("R3 load 7", count, 7);
    // held load suppresses counting
    en_par = 1; en_car = 1; tick();
    chk("R3 load held", count, 7);
    load_n = 1;
    model = 7;
    for (int i = 0; i < 6; i++) begin
      tick(); model = (model + 1) % 10;
      chk("R4 count seq", count, model);
      chk("R6 tc", tc, model == 9);
    end
    // hold with either enable low; tc depends on en_car only
    din = 9; load_n = 0; tick(); load_n = 1;
    en_par = 0; tick();
    chk("R5 hold en_par low", count, 9);
    chk("R6 tc ignores en_par", tc, 1);
    en_par = 1; en_car = 0; #1;
    chk("R6 tc gated by en_car", tc, 0);
    tick();
    chk("R5 hold en_car low", count, 9);
    en_car = 1;
    // async clear mid-cycle, overriding load
    load_n = 0; din = 5; #1; clr_n = 0; #1;
    chk("R1 async immediate", count, 0);
    tick();
    chk("R2 clear beats load", count, 0);
    clr_n = 1; load_n = 1;
    // illegal codes
    for (int c = 10; c < 16; c++) begin
      din = 4'(c); load_n = 0; tick(); load_n = 1;
      chk("R6 no tc on illegal", tc, 0);
      model = c;
      for (int k = 0; k < 2; k++) begin
        tick(); model = esc(model);
        chk("R7 escape", count, model);
      end
      chk("R7 within two", int'(count <= 9), 1);
    end
    // sync clear
    s_din = 6; s_load_n = 0; tick(); s_load_n = 1;
    s_clr_n = 0; #1;
    chk("R1 sync waits edge", s_cnt, 6);
    tick();
    chk("R1 sync cleared", s_cnt, 0);
    s_clr_n = 1;
    // chain
    c_clr_n = 1; c_ep = 1;
    model = 0;
    for (int i = 0; i < 1100; i++) begin
      c_ep = !((i % 37) == 5 || (i % 101) == 9);
      tick();
      if (c_ep) model = (model + 1) % 1000;
      chk("R8 chain", d2 * 100 + d1 * 10 + d0, model);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule